// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a parallel NOR-style memory bus. It watches write cycles, each one an address plus a 16-bit data word, and follows the multi-cycle unlock and command protocol that the host uses to start memory operations. When a sequence completes, the block emits a one-cycle strobe with an operation code. The strobe carries the address and data of the final write. For buffered programming it also carries the word index or word count.

The memory array, the embedded program and erase engines, and status polling all live outside this block. They take their work from the strobes. In command cycles only the low data byte and the low twelve address bits are decoded. Any write that breaks a sequence parks the decoder in an error state until a reset command arrives.

Top module: `nvm_cmd_decoder`

## Requirements
- R1: After reset, `op_stb`, `abort_o`, `err_o` and `byp_o` are 0, and `op_kind` is 0.
- R2: A write is taken when `wr_valid` is 1 at a rising clock edge. A completed command raises `op_stb` for exactly the following cycle, and only after a taken write. With the strobe, `op_addr`/`op_data` hold that write's address and data, and `op_kind` holds the code: 1 reset, 2 autoselect, 3 program, 4 buffer load, 5 buffer commit, 6 sector erase, 7 chip erase, 8 suspend, 9 resume, 10 configuration write, 11 bypass entry, 12 bypass exit.
- R3: The unlock pair is command byte AA at address 555 and then 55 at 2AA, with only address bits 11:0 compared. Following it with A0 at 555 and then any address/data pair gives code 3 for that pair.
- R4: Data bits 15:8 are ignored in command cycles. After the unlock pair, 90 at 555 gives code 2.
- R5: The unlock pair, 80 at 555 and the unlock pair again, followed by 10 at 555, gives code 7. Followed instead by 30 at any address, it gives code 6 with that sector address.
- R6: From idle, a single write of F0 to any address gives code 1. A single write of B0 gives code 8, and a single write of 30 gives code 9.
- R7: After the unlock pair, 25 at a sector address is followed by a count N-1 (full 16-bit word, at most 31). N address/data writes follow, each giving code 4 with `op_cnt` equal to its index 0..N-1. Then 29 at an address whose bits above bit 13 match the sector gives code 5 with `op_cnt` = N-1.
- R8: The block pulses `abort_o` for one cycle and enters the error state in three cases: a buffer count above 31, a buffer word outside the 32-word aligned page of the first word, or a buffer word whose offset is below the first word's.
- R9: The unlock pair, then D0 at 555, then CR0 at offset 000, then CR1 at offset 001, gives code 10 with `op_data` = CR1 and `cfg_first` = CR0. A write at offset 001 directly after D0 ends the sequence without a strobe, and `cfg_first` keeps its previous value.
- R10: After the unlock pair, 20 at 555 gives code 11 and sets `byp_o`. In bypass the address is ignored and the sequences are: A0 then a pair gives code 3; 80 then 30 gives code 6; 80 then 10 gives code 7; 90 then 00 gives code 12 and clears `byp_o`.
- R11: Any write that breaks a sequence sets `err_o` and clears `byp_o`. While in error, every write is ignored except command byte F0, which gives code 1 and clears `err_o`.
- R12: Cycles with `wr_valid` low change no output and do not disturb a sequence in progress.
- R13: In a data cycle (program data, buffer count or word, CR0/CR1), a data byte of F0 is data, not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write cycle is present this clock |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data |
| op_stb | output | 1 | One-cycle operation strobe |
| op_kind | output | 4 | Operation code (see R2) |
| op_addr | output | AW | Address of the completing write |
| op_data | output | 16 | Data of the completing write |
| op_cnt | output | CNT_W | Buffer word index or word count minus one |
| cfg_first | output | 16 | Last accepted first configuration word |
| abort_o | output | 1 | One-cycle buffer abort pulse |
| err_o | output | 1 | Decoder is in the error state |
| byp_o | output | 1 | Decoder is in unlock-bypass mode |

## Verification
The checker covers several properties on every cycle:
- an abort pulse always comes with the error state;
- the error state is left only with a reset strobe;
- a strobe only follows a taken write;
- bypass is entered only with an entry strobe and left only through exit, reset or error;
- idle cycles change nothing.

Whether a given sequence yields the right code, address, data and buffer indices can only be shown by the bench's scenarios. The same holds for the sector match on commit, page and ordering aborts, the CR1-only case, and F0 handled as data.

// File: rtl/ncd_pkg.sv
package ncd_pkg;
  localparam int CMP_W = 12;
  localparam logic [CMP_W-1:0] ADR_UNL1 = 12'h555;
  localparam logic [CMP_W-1:0] ADR_UNL2 = 12'h2AA;
  localparam logic [CMP_W-1:0] ADR_CR0  = 12'h000;
  localparam logic [CMP_W-1:0] ADR_CR1  = 12'h001;

  localparam logic [7:0] C_UNL1   = 8'hAA;
  localparam logic [7:0] C_UNL2   = 8'h55;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_AUTO   = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_CFG    = 8'hD0;
  localparam logic [7:0] C_BUF    = 8'h25;
  localparam logic [7:0] C_COMMIT = 8'h29;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] C_BEXIT1 = 8'h90;
  localparam logic [7:0] C_BEXIT2 = 8'h00;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_RESET      = 4'd1,
    OP_AUTOSEL    = 4'd2,
    OP_PROG       = 4'd3,
    OP_BUF_LOAD   = 4'd4,
    OP_BUF_COMMIT = 4'd5,
    OP_SECT_ERASE = 4'd6,
    OP_CHIP_ERASE = 4'd7,
    OP_SUSPEND    = 4'd8,
    OP_RESUME     = 4'd9,
    OP_CFG_WRITE  = 4'd10,
    OP_BYP_ENTER  = 4'd11,
    OP_BYP_EXIT   = 4'd12
  } op_kind_e;

  typedef enum logic [4:0] {
    S_IDLE, S_UNL2, S_CMD, S_PROG_WR,
    S_ER_UNL1, S_ER_UNL2, S_ER_FIN,
    S_CFG0, S_CFG1,
    S_BUF_CNT, S_BUF_WORD, S_BUF_COMMIT,
    S_BYP_IDLE, S_BYP_PROG, S_BYP_ERASE, S_BYP_EXIT,
    S_ERR
  } seq_state_e;
endpackage

// File: rtl/ncd_match.sv
module ncd_match
  import ncd_pkg::*;
(
  input  logic [CMP_W-1:0] addr_lo,
  output logic             at_unl1,
  output logic             at_unl2,
  output logic             at_cr0,
  output logic             at_cr1
);
  localparam int NKEY = 4;
  localparam logic [NKEY-1:0][CMP_W-1:0] KEYS = {ADR_CR1, ADR_CR0, ADR_UNL2, ADR_UNL1};

  logic [NKEY-1:0] hit;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    assign hit[g] = (addr_lo == KEYS[g]);
  end

  assign at_unl1 = hit[0];
  assign at_unl2 = hit[1];
  assign at_cr0  = hit[2];
  assign at_cr1  = hit[3];
endmodule

// File: rtl/ncd_buf_track.sv
module ncd_buf_track #(
  parameter int AW        = 24,
  parameter int BUF_WORDS = 32,
  localparam int PG_LOG   = $clog2(BUF_WORDS),
  localparam int CNT_W    = PG_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             word_acc,
  input  logic [AW-1:0]    addr,
  output logic             last_word,
  output logic             page_ok,
  output logic [CNT_W-1:0] word_idx,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0]     idx_q, total_q;
  logic [AW-PG_LOG-1:0] base_pg_q;
  logic [PG_LOG-1:0]    base_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      total_q    <= '0;
      base_pg_q  <= '0;
      base_off_q <= '0;
    end else if (cnt_load) begin
      idx_q   <= '0;
      total_q <= cnt_val;
    end else if (word_acc) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == '0) begin
        base_pg_q  <= addr[AW-1:PG_LOG];
        base_off_q <= addr[PG_LOG-1:0];
      end
    end
  end

  assign page_ok   = (idx_q == '0) ||
                     ((addr[AW-1:PG_LOG] == base_pg_q) && (addr[PG_LOG-1:0] >= base_off_q));
  assign last_word = (idx_q == total_q);
  assign word_idx  = idx_q;
  assign total     = total_q;
endmodule

// File: rtl/ncd_fsm.sv
module ncd_fsm
  import ncd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int SECT_LOG  = 14,
  parameter int BUF_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   data,
  input  logic          at_unl1,
  input  logic          at_unl2,
  input  logic          at_cr0,
  input  logic          at_cr1,
  input  logic          page_ok,
  input  logic          last_word,
  output op_kind_e      op_d,
  output logic          abort_d,
  output logic          cnt_load,
  output logic          word_acc,
  output logic          cr0_load,
  output logic          err,
  output logic          byp
);
  localparam logic [15:0] MAX_CNT = 16'(BUF_WORDS - 1);

  seq_state_e state_q, state_d;
  logic [AW-SECT_LOG-1:0] sa_q;
  logic       sa_load;
  logic [7:0] cmd;
  logic       data_cycle;
  logic       sect_hit;

  assign cmd        = data[7:0];
  assign sect_hit   = (addr[AW-1:SECT_LOG] == sa_q);
  assign data_cycle = state_q inside {S_PROG_WR, S_BYP_PROG, S_BUF_CNT, S_BUF_WORD, S_CFG0, S_CFG1};

  always_comb begin
    state_d  = state_q;
    op_d     = OP_NONE;
    abort_d  = 1'b0;
    cnt_load = 1'b0;
    word_acc = 1'b0;
    cr0_load = 1'b0;
    sa_load  = 1'b0;
    if (wr_valid) begin
      if (cmd == C_RESET && !data_cycle) begin
        state_d = S_IDLE;
        op_d    = OP_RESET;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (at_unl1 && cmd == C_UNL1) state_d = S_UNL2;
            else if (cmd == C_SUSP)       op_d = OP_SUSPEND;
            else if (cmd == C_RESUME)     op_d = OP_RESUME;
            else                          state_d = S_ERR;
          end
          S_UNL2:    state_d = (at_unl2 && cmd == C_UNL2) ? S_CMD : S_ERR;
          S_CMD: begin
            state_d = S_ERR;
            if (at_unl1 && cmd == C_AUTO) begin
              op_d = OP_AUTOSEL; state_d = S_IDLE;
            end else if (at_unl1 && cmd == C_PROG) begin
              state_d = S_PROG_WR;
            end else if (at_unl1 && cmd == C_BYP) begin
              op_d = OP_BYP_ENTER; state_d = S_BYP_IDLE;
            end else if (at_unl1 && cmd == C_ERASE) begin
              state_d = S_ER_UNL1;
            end else if (at_unl1 && cmd == C_CFG) begin
              state_d = S_CFG0;
            end else if (cmd == C_BUF) begin
              sa_load = 1'b1; state_d = S_BUF_CNT;
            end
          end
          S_PROG_WR: begin
            op_d = OP_PROG; state_d = S_IDLE;
          end
          S_ER_UNL1: state_d = (at_unl1 && cmd == C_UNL1) ? S_ER_UNL2 : S_ERR;
          S_ER_UNL2: state_d = (at_unl2 && cmd == C_UNL2) ? S_ER_FIN : S_ERR;
          S_ER_FIN: begin
            state_d = S_IDLE;
            if (at_unl1 && cmd == C_CHIP) op_d = OP_CHIP_ERASE;
            else if (cmd == C_SECT)       op_d = OP_SECT_ERASE;
            else                          state_d = S_ERR;
          end
          S_CFG0: begin
            if (at_cr0) begin
              cr0_load = 1'b1; state_d = S_CFG1;
            end else if (at_cr1) begin
              state_d = S_IDLE;
            end else begin
              state_d = S_ERR;
            end
          end
          S_CFG1: begin
            if (at_cr1) begin
              op_d = OP_CFG_WRITE; state_d = S_IDLE;
            end else begin
              state_d = S_ERR;
            end
          end
          S_BUF_CNT: begin
            if (data > MAX_CNT) begin
              abort_d = 1'b1; state_d = S_ERR;
            end else begin
              cnt_load = 1'b1; state_d = S_BUF_WORD;
            end
          end
          S_BUF_WORD: begin
            if (!page_ok) begin
              abort_d = 1'b1; state_d = S_ERR;
            end else begin
              op_d = OP_BUF_LOAD; word_acc = 1'b1;
              if (last_word) state_d = S_BUF_COMMIT;
            end
          end
          S_BUF_COMMIT: begin
            if (cmd == C_COMMIT && sect_hit) begin
              op_d = OP_BUF_COMMIT; state_d = S_IDLE;
            end else begin
              state_d = S_ERR;
            end
          end
          S_BYP_IDLE: begin
            if (cmd == C_PROG)        state_d = S_BYP_PROG;
            else if (cmd == C_ERASE)  state_d = S_BYP_ERASE;
            else if (cmd == C_BEXIT1) state_d = S_BYP_EXIT;
            else                      state_d = S_ERR;
          end
          S_BYP_PROG: begin
            op_d = OP_PROG; state_d = S_BYP_IDLE;
          end
          S_BYP_ERASE: begin
            state_d = S_BYP_IDLE;
            if (cmd == C_SECT)      op_d = OP_SECT_ERASE;
            else if (cmd == C_CHIP) op_d = OP_CHIP_ERASE;
            else                    state_d = S_ERR;
          end
          S_BYP_EXIT: begin
            if (cmd == C_BEXIT2) begin
              op_d = OP_BYP_EXIT; state_d = S_IDLE;
            end else begin
              state_d = S_ERR;
            end
          end
          default: state_d = S_ERR;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sa_q    <= '0;
    end else begin
      state_q <= state_d;
      if (sa_load) sa_q <= addr[AW-1:SECT_LOG];
    end
  end

  assign err = (state_q == S_ERR);
  assign byp = state_q inside {S_BYP_IDLE, S_BYP_PROG, S_BYP_ERASE, S_BYP_EXIT};
endmodule

// File: rtl/nvm_cmd_decoder.sv
module nvm_cmd_decoder
  import ncd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int SECT_LOG  = 14,
  parameter int BUF_WORDS = 32,
  localparam int CNT_W    = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_data,
  output logic             op_stb,
  output logic [3:0]       op_kind,
  output logic [AW-1:0]    op_addr,
  output logic [15:0]      op_data,
  output logic [CNT_W-1:0] op_cnt,
  output logic [15:0]      cfg_first,
  output logic             abort_o,
  output logic             err_o,
  output logic             byp_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic at_unl1, at_unl2, at_cr0, at_cr1;
  logic page_ok, last_word, cnt_load, word_acc, cr0_load, abort_d, err, byp;
  logic [CNT_W-1:0] word_idx, total;
  op_kind_e op_d;

  ncd_match u_match (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .at_unl1 (at_unl1),
    .at_unl2 (at_unl2),
    .at_cr0  (at_cr0),
    .at_cr1  (at_cr1)
  );

  ncd_buf_track #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_load  (cnt_load),
    .cnt_val   (wr_data[CNT_W-1:0]),
    .word_acc  (word_acc),
    .addr      (wr_addr),
    .last_word (last_word),
    .page_ok   (page_ok),
    .word_idx  (word_idx),
    .total     (total)
  );

  ncd_fsm #(.AW(AW), .SECT_LOG(SECT_LOG), .BUF_WORDS(BUF_WORDS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_valid  (wr_valid),
    .addr      (wr_addr),
    .data      (wr_data),
    .at_unl1   (at_unl1),
    .at_unl2   (at_unl2),
    .at_cr0    (at_cr0),
    .at_cr1    (at_cr1),
    .page_ok   (page_ok),
    .last_word (last_word),
    .op_d      (op_d),
    .abort_d   (abort_d),
    .cnt_load  (cnt_load),
    .word_acc  (word_acc),
    .cr0_load  (cr0_load),
    .err       (err),
    .byp       (byp)
  );

  logic             fire;
  logic             op_stb_q, abort_q;
  op_kind_e         op_kind_q;
  logic [AW-1:0]    op_addr_q;
  logic [15:0]      op_data_q, cr0_q;
  logic [CNT_W-1:0] op_cnt_q, cnt_sel;

  assign fire = wr_valid && (op_d != OP_NONE);

  always_comb begin
    unique case (op_d)
      OP_BUF_LOAD:   cnt_sel = word_idx;
      OP_BUF_COMMIT: cnt_sel = total;
      default:       cnt_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_stb_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      op_stb_q <= fire;
      abort_q  <= wr_valid && abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_kind_q <= OP_NONE;
      op_addr_q <= '0;
      op_data_q <= '0;
      op_cnt_q  <= '0;
    end else if (fire) begin
      op_kind_q <= op_d;
      op_addr_q <= wr_addr;
      op_data_q <= wr_data;
      op_cnt_q  <= cnt_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)              cr0_q <= '0;
    else if (wr_valid && cr0_load) cr0_q <= wr_data;
  end

  assign op_stb    = op_stb_q;
  assign op_kind   = op_kind_q;
  assign op_addr   = op_addr_q;
  assign op_data   = op_data_q;
  assign op_cnt    = op_cnt_q;
  assign cfg_first = cr0_q;
  assign abort_o   = abort_q;
  assign err_o     = err;
  assign byp_o     = byp;
endmodule

// File: rtl/ncd_chk.sv
module ncd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       op_stb,
  input logic [3:0] op_kind,
  input logic       abort_o,
  input logic       err_o,
  input logic       byp_o
);
  // R8
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> err_o);

  // R11
  err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> (op_stb && op_kind == 4'd1));

  // R2
  stb_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |-> $past(wr_valid));

  // R2
  stb_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |-> (op_kind != 4'd0));

  // R10
  byp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byp_o) |-> (op_stb && op_kind == 4'd11));

  // R10
  byp_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byp_o) |-> (err_o || (op_stb && (op_kind == 4'd12 || op_kind == 4'd1))));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!op_stb && !abort_o && $stable(err_o) && $stable(byp_o)));
endmodule

bind nvm_cmd_decoder ncd_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .op_stb   (op_stb),
  .op_kind  (op_kind),
  .abort_o  (abort_o),
  .err_o    (err_o),
  .byp_o    (byp_o)
);

// File: tb/nvm_cmd_decoder_tb.sv
module nvm_cmd_decoder_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 24;
  localparam int CNT_W = 5;
  localparam logic [3:0] K_RESET = 1, K_AUTO = 2, K_PROG = 3, K_LOAD = 4, K_COMMIT = 5,
                         K_SECT = 6, K_CHIP = 7, K_SUSP = 8, K_RESUME = 9, K_CFG = 10,
                         K_BIN = 11, K_BOUT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic op_stb, abort_o, err_o, byp_o;
  logic [3:0] op_kind;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data, cfg_first;
  logic [CNT_W-1:0] op_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvm_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_stb(op_stb), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .op_cnt(op_cnt), .cfg_first(cfg_first), .abort_o(abort_o), .err_o(err_o), .byp_o(byp_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] at(input logic [11:0] lo);
    logic [AW-1:0] a;
    a = AW'($urandom);
    a[11:0] = lo;
    return a;
  endfunction

  function automatic logic [15:0] cw(input logic [7:0] c);
    return {8'($urandom), c};
  endfunction

  task automatic exp_op(input logic [3:0] k, input logic [AW-1:0] a, input logic [15:0] d,
                        input string req);
    chk(op_stb === 1'b1 && op_kind === k, req, "strobe/kind", {op_stb, op_kind}, {1'b1, k});
    chk(op_addr === a && op_data === d, req, "addr/data", {op_addr, op_data}, {a, d});
  endtask

  task automatic exp_none(input string req);
    chk(op_stb === 1'b0 && abort_o === 1'b0, req, "no strobe", {op_stb, abort_o}, 0);
  endtask

  task automatic exp_flags(input bit e, input bit b, input string req);
    chk(err_o === e && byp_o === b, req, "err/byp", {err_o, byp_o}, {e, b});
  endtask

  task automatic unlock(input string req);
    wr(at(12'h555), cw(8'hAA)); exp_none(req);
    wr(at(12'h2AA), cw(8'h55)); exp_none(req);
  endtask

  task automatic do_reset_cmd(input string req);
    logic [AW-1:0] a;
    logic [15:0] d;
    a = AW'($urandom); d = cw(8'hF0);
    wr(a, d); exp_op(K_RESET, a, d, req); exp_flags(0, 0, req);
  endtask

  initial begin
    logic [AW-1:0] a, pg, ca;
    logic [15:0] d, cr0v, cr1v;
    int n, off0, sel;
    void'($urandom(32'h1d5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(op_stb === 0 && abort_o === 0 && err_o === 0 && byp_o === 0 && op_kind === 0,
        "R1", "reset outputs", {op_stb, abort_o, err_o, byp_o, op_kind}, 0);

    // R3 / R4: random single-word programs with noisy upper address and data bits
    for (int i = 0; i < 20; i++) begin
      unlock("R3");
      wr(at(12'h555), cw(8'hA0)); exp_none("R3");
      a = AW'($urandom); d = 16'($urandom);
      wr(a, d); exp_op(K_PROG, a, d, "R3"); exp_flags(0, 0, "R3");
    end

    // R4 autoselect, upper byte ignored
    unlock("R4");
    a = at(12'h555); d = 16'h3C90;
    wr(a, d); exp_op(K_AUTO, a, d, "R4");

    // R5 chip and sector erase
    for (int i = 0; i < 6; i++) begin
      unlock("R5");
      wr(at(12'h555), cw(8'h80)); exp_none("R5");
      unlock("R5");
      if (i % 2 == 0) begin
        a = at(12'h555); d = cw(8'h10);
        wr(a, d); exp_op(K_CHIP, a, d, "R5");
      end else begin
        a = AW'($urandom); d = cw(8'h30);
        wr(a, d); exp_op(K_SECT, a, d, "R5");
      end
    end

    // R6 single-cycle commands
    do_reset_cmd("R6");
    a = AW'($urandom); d = cw(8'hB0); wr(a, d); exp_op(K_SUSP, a, d, "R6");
    a = AW'($urandom); d = cw(8'h30); wr(a, d); exp_op(K_RESUME, a, d, "R6");

    // R7 buffered programming, random lengths and start offsets
    for (int it = 0; it < 12; it++) begin
      n = (it == 0) ? 32 : ((it == 1) ? 1 : 1 + $urandom_range(31));
      off0 = $urandom_range(32 - n);
      pg = AW'($urandom) & ~AW'(31);
      unlock("R7");
      wr(pg, cw(8'h25)); exp_none("R7");
      wr(AW'($urandom), 16'(n - 1)); exp_none("R7");
      for (int i = 0; i < n; i++) begin
        a = pg + AW'(off0 + i);
        d = (i == 0) ? 16'h00F0 : 16'($urandom);
        wr(a, d); exp_op(K_LOAD, a, d, "R7");
        chk(op_cnt === CNT_W'(i), "R7", "word index", op_cnt, i);
      end
      ca = {pg[AW-1:14], 14'($urandom)};
      d = cw(8'h29);
      wr(ca, d); exp_op(K_COMMIT, ca, d, "R7");
      chk(op_cnt === CNT_W'(n - 1), "R7", "commit count", op_cnt, n - 1);
      exp_flags(0, 0, "R7");
    end

    // R8 aborts
    pg = AW'($urandom) & ~AW'(31);
    unlock("R8"); wr(pg, cw(8'h25)); wr(pg, 16'd32);
    chk(abort_o === 1'b1, "R8", "abort on count 32", abort_o, 1); exp_flags(1, 0, "R8");
    do_reset_cmd("R8");
    unlock("R8"); wr(pg, cw(8'h25)); wr(pg, 16'd3);
    wr(pg + 4, 16'h1111); exp_op(K_LOAD, pg + 4, 16'h1111, "R8");
    wr(pg + 2, 16'h2222);
    chk(abort_o === 1'b1, "R8", "abort on lower offset", abort_o, 1); exp_flags(1, 0, "R8");
    do_reset_cmd("R8");
    unlock("R8"); wr(pg, cw(8'h25)); wr(pg, 16'd3);
    wr(pg, 16'h3333); exp_op(K_LOAD, pg, 16'h3333, "R8");
    wr(pg + 32, 16'h4444);
    chk(abort_o === 1'b1, "R8", "abort on other page", abort_o, 1); exp_flags(1, 0, "R8");
    idle(1);
    chk(abort_o === 1'b0, "R8", "abort is one cycle", abort_o, 0);
    do_reset_cmd("R8");

    // R9 configuration write, then CR1 without CR0
    cr0v = 16'($urandom); cr1v = 16'($urandom);
    unlock("R9"); wr(at(12'h555), cw(8'hD0)); exp_none("R9");
    wr(at(12'h000), cr0v); exp_none("R9");
    a = at(12'h001); wr(a, cr1v); exp_op(K_CFG, a, cr1v, "R9");
    chk(cfg_first === cr0v, "R9", "first word", cfg_first, cr0v);
    unlock("R9"); wr(at(12'h555), cw(8'hD0));
    wr(at(12'h001), 16'hBEEF); exp_none("R9"); exp_flags(0, 0, "R9");
    chk(cfg_first === cr0v, "R9", "first word kept", cfg_first, cr0v);
    a = AW'($urandom); d = cw(8'hB0); wr(a, d); exp_op(K_SUSP, a, d, "R9");

    // R10 unlock bypass
    unlock("R10");
    a = at(12'h555); d = cw(8'h20); wr(a, d); exp_op(K_BIN, a, d, "R10"); exp_flags(0, 1, "R10");
    for (int i = 0; i < 12; i++) begin
      sel = $urandom_range(2);
      if (sel == 0) begin
        wr(AW'($urandom), cw(8'hA0)); exp_none("R10");
        a = AW'($urandom); d = (i == 0) ? 16'h12F0 : 16'($urandom);
        wr(a, d); exp_op(K_PROG, a, d, "R10");
      end else begin
        wr(AW'($urandom), cw(8'h80)); exp_none("R10");
        a = AW'($urandom); d = cw(sel == 1 ? 8'h30 : 8'h10);
        wr(a, d); exp_op(sel == 1 ? K_SECT : K_CHIP, a, d, "R10");
      end
      exp_flags(0, 1, "R10");
    end
    wr(AW'($urandom), cw(8'h90)); exp_none("R10");
    a = AW'($urandom); d = cw(8'h00); wr(a, d); exp_op(K_BOUT, a, d, "R10"); exp_flags(0, 0, "R10");

    // R11 error handling
    unlock("R11");
    wr(at(12'h555), cw(8'h80));
    wr(at(12'h555), cw(8'hAA)); wr(at(12'h2AB), cw(8'h55));
    exp_none("R11"); exp_flags(1, 0, "R11");
    unlock("R11");
    wr(at(12'h555), cw(8'hA0)); exp_none("R11");
    wr(AW'($urandom), 16'h5A5A); exp_none("R11"); exp_flags(1, 0, "R11");
    do_reset_cmd("R11");
    unlock("R11"); wr(at(12'h555), cw(8'h20)); exp_flags(0, 1, "R11");
    wr(AW'($urandom), cw(8'h34)); exp_none("R11"); exp_flags(1, 0, "R11");
    do_reset_cmd("R11");
    wr(AW'($urandom), cw(8'h77)); exp_flags(1, 0, "R11");
    do_reset_cmd("R11");

    // R12 idle cycles inside a sequence
    wr(at(12'h555), cw(8'hAA)); idle(3); exp_none("R12"); exp_flags(0, 0, "R12");
    wr(at(12'h2AA), cw(8'h55)); idle(2); exp_none("R12");
    wr(at(12'h555), cw(8'hA0)); idle(4); exp_none("R12");
    a = AW'($urandom); d = 16'($urandom);
    wr(a, d); exp_op(K_PROG, a, d, "R12");

    // R13 F0 carried as program data
    unlock("R13"); wr(at(12'h555), cw(8'hA0));
    a = AW'($urandom); d = 16'h00F0;
    wr(a, d); exp_op(K_PROG, a, d, "R13"); exp_flags(0, 0, "R13");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule